// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Register

This block gathers five one-cycle interrupt events (timer A, timer B, clock alarm, serial port and an external flag pin) into a latched flag register. It pairs the flags with a 5-bit enable mask and drives an interrupt request when an enabled flag is pending. A flag is latched whether or not it is enabled. The summary bit, bit 7 of the read byte, mirrors the request line.

Software changes the mask with one write. Data bit 7 of the write chooses whether the other bits turn enables on or off. A write that turns on an enable for a flag that is already latched raises the request in the next cycle. A read returns the flag byte. In the same edge it clears every flag and releases the request. An event that arrives in the same cycle as the read is kept. A write to the serial data register counts as a serial event, which stands in for a real transfer-complete signal.

Top module: `irq_collect`

## Requirements
- R1: Reset clears all flags, the summary bit, the request and the mask. After reset, an event alone leaves `irq` low.
- R2: An event pulse on `ev_pulse[k]` sets bit k of the flag byte in the next cycle, whatever the mask holds. The bits are: bit 0 timer A (0x01), bit 1 timer B (0x02), bit 2 alarm (0x04), bit 3 serial (0x08), bit 4 flag pin (0x10). Bits 6:5 of `rd_data` always read 0.
- R3: An event whose mask bit is set drives `rd_data[7]` and `irq` high in the next cycle. An event whose mask bit is clear leaves both unchanged.
- R4: A write with `wr_data[7]`=1 ORs `wr_data[4:0]` into the mask.
- R5: A write with `wr_data[7]`=0 clears every mask bit that is 1 in `wr_data[4:0]`.
- R6: After a mask write, if (flags AND mask) is nonzero, `rd_data[7]` and `irq` go high in the next cycle.
- R7: While `rd_en` is high, `rd_data` shows the current flag byte. From the next cycle on, flags, summary and `irq` are 0.
- R8: An event in the same cycle as a read survives the clear. Its flag is set after the read, and if its mask bit is set, `irq` is set as well.
- R9: A pulse on `ser_wr` sets flag bit 3 exactly as `ev_pulse[3]` does, including the raising of `irq` when that bit is enabled.
- R10: Once `irq` is high, it stays high until a read, even if the mask bit that raised it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 5 | One-cycle source events, bit map as in R2 |
| ser_wr | input | 1 | Serial data register write strobe, acts as the serial event |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data; bit 7 selects set (1) or clear (0) |
| rd_en | input | 1 | Flag register read strobe (read-clear) |
| rd_data | output | 8 | Summary bit 7, flags 4:0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read that collides with a new event. A flag already latched by an earlier, disabled event must appear in the read value. The colliding event must then be the only flag left, with the request raised from its enable alone. The bench first latches a disabled flag and enables a different source. It then drives the read and that source's pulse in the same cycle, and checks both the read byte and the state one cycle later. The late-enable path is reached in a similar way: a flag is latched while masked, and only then is the mask write issued.

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int N_SRC   = 5,
  parameter int SER_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_pulse,
  input  logic             ser_wr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             irq
);
  localparam int PAD = 7 - N_SRC;

  logic [N_SRC-1:0] flags, mask;
  logic             summ;

  logic [N_SRC-1:0] ev_all, flags_nx, mask_nx;
  logic             summ_nx;

  assign ev_all = ev_pulse | (N_SRC'(ser_wr) << SER_BIT);

  always_comb begin
    mask_nx = mask;
    if (wr_en) begin
      if (wr_data[7]) mask_nx = mask | wr_data[N_SRC-1:0];
      else            mask_nx = mask & ~wr_data[N_SRC-1:0];
    end
  end

  assign flags_nx = (rd_en ? '0 : flags) | ev_all;
  assign summ_nx  = (rd_en ? 1'b0 : summ)
                  | (|(ev_all & mask))
                  | (wr_en & (|(flags_nx & mask_nx)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
      summ  <= 1'b0;
    end else begin
      flags <= flags_nx;
      mask  <= mask_nx;
      summ  <= summ_nx;
    end
  end

  assign rd_data = {summ, {PAD{1'b0}}, flags};
  assign irq     = summ;
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk #(
  parameter int N_SRC   = 5,
  parameter int SER_BIT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] ev_pulse,
  input logic             ser_wr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic             irq
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != '0) |=> ((rd_data[N_SRC-1:0] & $past(ev_pulse)) == $past(ev_pulse))); // R2

  AST_SER_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ser_wr |=> rd_data[SER_BIT]); // R9

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ev_pulse == '0 && !ser_wr && !wr_en) |=> (rd_data == 8'h00 && !irq)); // R7

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq); // R10

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[N_SRC-1:0] != '0)); // R3

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_pulse != '0 || ser_wr || wr_en)); // R6

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00); // R2
endmodule

bind irq_collect irq_collect_chk #(.N_SRC(N_SRC), .SER_BIT(SER_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ser_wr(ser_wr),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_irq_collect.sv
module tb_irq_collect;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ev_pulse;
  logic       ser_wr, wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rd_seen;

  irq_collect dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ser_wr(ser_wr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge, capture rd_data mid-cycle, end at next negedge.
  task automatic step(logic [4:0] ev, logic sw, logic we, logic [7:0] wd, logic re);
    ev_pulse = ev; ser_wr = sw; wr_en = we; wr_data = wd; rd_en = re;
    #1 rd_seen = rd_data;
    @(negedge clk);
    ev_pulse = '0; ser_wr = 0; wr_en = 0; wr_data = '0; rd_en = 0;
  endtask

  task automatic state_is(string req, logic [7:0] f, logic i);
    chk(req, {irq, rd_data}, {i, f});
  endtask

  task automatic t_reset;
    state_is("R1 reset state", 8'h00, 0);
    step(5'h1F, 0, 0, 8'h00, 0);
    state_is("R1 mask zero after reset", 8'h1F, 0);
    step(0, 0, 0, 0, 1);
    state_is("R7 cleared", 8'h00, 0);
  endtask

  task automatic t_latch;
    for (int k = 0; k < 5; k++) begin
      step(5'(1 << k), 0, 0, 0, 0);
      state_is($sformatf("R2 source %0d latched unmasked", k), 8'(1 << k), 0);
      step(0, 0, 0, 0, 1);
      chk("R7 read value", {1'b0, rd_seen}, {1'b0, 8'(1 << k)});
      state_is("R7 cleared after read", 8'h00, 0);
    end
  endtask

  task automatic t_enable;
    step(0, 0, 1, 8'hE1, 0);
    state_is("R4 mask write changes no flag", 8'h00, 0);
    step(5'h01, 0, 0, 0, 0);
    state_is("R3 enabled event raises irq", 8'h81, 1);
    step(0, 0, 0, 0, 1);
    chk("R7 read returns summary", {1'b0, rd_seen}, 9'h081);
    state_is("R7 read releases irq", 8'h00, 0);
  endtask

  task automatic t_clear_mask;
    step(0, 0, 1, 8'h01, 0);
    step(5'h01, 0, 0, 0, 0);
    state_is("R5 cleared enable gives no irq", 8'h01, 0);
    step(0, 0, 0, 0, 1);
  endtask

  task automatic t_late_enable;
    step(5'h02, 0, 0, 0, 0);
    state_is("R6 flag latched while masked", 8'h02, 0);
    step(0, 0, 1, 8'h84, 0);
    state_is("R6 unrelated enable keeps irq low", 8'h02, 0);
    step(0, 0, 1, 8'h82, 0);
    state_is("R6 enable of latched flag raises irq", 8'h82, 1);
    step(0, 0, 1, 8'h02, 0);
    state_is("R10 irq kept after mask clear", 8'h82, 1);
    step(0, 0, 0, 0, 1);
    state_is("R7 clear after late enable", 8'h00, 0);
  endtask

  task automatic t_race;
    step(5'h01, 0, 0, 0, 0);
    state_is("R8 prior disabled flag", 8'h01, 0);
    step(5'h04, 0, 0, 0, 1);
    chk("R8 read sees old flag only", {1'b0, rd_seen}, 9'h001);
    state_is("R8 colliding event survives", 8'h84, 1);
    step(0, 0, 0, 0, 1);
    state_is("R8 cleared afterwards", 8'h00, 0);
  endtask

  task automatic t_ser;
    step(0, 1, 0, 0, 0);
    state_is("R9 serial write sets flag", 8'h08, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 8'h88, 0);
    step(0, 1, 0, 0, 0);
    state_is("R9 enabled serial write raises irq", 8'h88, 1);
    step(0, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ev_pulse = '0; ser_wr = 0; wr_en = 0; wr_data = '0; rd_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_enable;
    t_clear_mask;
    t_late_enable;
    t_race;
    t_ser;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule